// File: doc/BRIEF.md
# Multi-window readout address generator

This block walks a pixel array through up to four rectangular regions of interest and presents one readout address per beat. Each region has a first row, a last row, a first column in kernel units and a kernel count per row. A frame-start pulse captures the whole configuration. The block then visits the active regions in index order and finishes each one before it starts the next.

Within a region the rows are scanned in order, and every kept kernel of a row is presented before the next row begins. Either axis may run backwards. Subsampling keeps a subset of the rows and columns, chosen by a pattern that is either two-on two-off (colour) or one-on one-off (monochrome).

The consumer takes addresses with a valid/step handshake. Markers flag the first and last address of each row, and a separate one-cycle pulse marks the end of the frame.

The controller has four states. IDLE waits for the frame-start pulse. SETUP selects the current region and loads its first row and column. EMIT presents addresses. FEND raises the frame-end pulse.

Its transitions are:
- IDLE→SETUP on a frame-start pulse.
- SETUP→EMIT when the region is not empty.
- SETUP→SETUP when the region is empty and a later active region exists.
- SETUP→FEND when the region is empty and it is the last active one.
- EMIT→EMIT on an accepted address that is not the last of its region, or while stalled.
- EMIT→SETUP on the last accepted address of a region that is not the last active one.
- EMIT→FEND on the last accepted address of the last active region.
- FEND→IDLE always.

Top module: `roi_addr_gen`

## Requirements
- R1: After reset, addr_valid, line_start, line_end and frame_end are 0, and no address is presented until a frame-start pulse arrives.
- R2: A frame-start pulse in the idle state captures the region count, all region fields and the four mode bits. Frame-start pulses and changes to any configuration input during a frame do not alter the address stream of that frame.
- R3: win_count encodes the number of active regions: 0 means 1 region, 1 means 2, 2 means 3 and 3 means 4. Regions are read in index order 0, 1, 2, 3, and regions beyond the count produce nothing.
- R4: For a region, y_addr = first row + row offset, with row offsets 0 through (last row - first row). x_addr = (first kernel + column offset) mod 64, with column offsets 0 through kernel count - 1. All columns of a row are presented before the next row.
- R5: A region whose last row is below its first row, or whose kernel count is 0, produces no addresses.
- R6: With rev_x = 1, columns within each row run from the highest kept offset down to 0. With rev_y = 1, rows run from the highest kept offset down to 0. The two bits act independently.
- R7: With sub_en = 1, only offsets counted from the region's first row and first kernel are kept. With sub_color = 0, an offset is kept when offset mod 2 = 0. With sub_color = 1, an offset is kept when offset mod 4 is 0 or 1. The rule applies to rows and columns alike, and reversal only reverses the order of the kept set.
- R8: While addr_valid = 1 and step_en = 0, the address and markers hold. An address is accepted when addr_valid and step_en are both 1. Within a region, the next address is presented in the cycle after each accepted one.
- R9: line_start is 1 with the first presented address of each row, and line_end is 1 with the last. Both are 1 together when a row keeps a single kernel.
- R10: After the last address of the frame is accepted, or after a frame in which every region is empty, frame_end is 1 for exactly one cycle with addr_valid = 0. The block then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Starts a frame when idle |
| step_en | input | 1 | Consumer accepts the presented address |
| win_count | input | 2 | Number of active regions minus one |
| y_start_flat | input | 40 | First row per region, region i at bits [10i+9:10i] |
| y_end_flat | input | 40 | Last row per region, same packing |
| x_start_flat | input | 24 | First kernel per region, region i at bits [6i+5:6i] |
| x_kernels_flat | input | 24 | Kernels per row per region, same packing |
| sub_en | input | 1 | Subsampling enable |
| sub_color | input | 1 | 1: keep two, skip two; 0: keep one, skip one |
| rev_x | input | 1 | Reverse column order |
| rev_y | input | 1 | Reverse row order |
| x_addr | output | 6 | Kernel column address |
| y_addr | output | 10 | Row address |
| addr_valid | output | 1 | An address is presented |
| line_start | output | 1 | First address of a row |
| line_end | output | 1 | Last address of a row |
| frame_end | output | 1 | One-cycle end-of-frame pulse |

## Verification
The walk is exercised with single and multiple regions and every region-count encoding. Regions left configured beyond the count show whether the count limits the walk. Empty regions placed at the start, the middle and the end, and a frame with every region empty, separate skipping from stalling and show where frame_end falls. Each reversal is run alone and both together, each with both subsampling patterns. The spans used give every remainder mod 4, which separates the kept-set rule from the order rule. A region starting near column 63 exposes wrap-around, and one-kernel rows test the markers coinciding. The consumer is driven always ready, randomly stalling and mostly stalled, which tells hold behaviour apart from gaps inside a region. A disturbed frame that changes inputs and pulses frame-start mid-frame shows that the configuration is captured.

// File: rtl/roi_pkg.sv
package roi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_EMIT  = 2'd2,
        ST_FEND  = 2'd3
    } roi_state_t;

    typedef struct packed {
        logic sub_en;
        logic sub_color;
        logic rev_x;
        logic rev_y;
    } roi_mode_t;

endpackage

// File: rtl/roi_axis.sv
// One scan axis: first kept offset, end test and next kept offset.
module roi_axis #(
    parameter int W = 6
) (
    input  logic [W-1:0] idx,
    input  logic [W-1:0] span,
    input  logic         sub_en,
    input  logic         sub_color,
    input  logic         rev,
    output logic [W-1:0] first_idx,
    output logic [W-1:0] next_idx,
    output logic         at_end
);

    logic [W-1:0] kmax;
    logic [W-1:0] stride;

    always_comb begin
        // highest offset within span that the pattern keeps
        if (!sub_en)
            kmax = span;
        else if (!sub_color)
            kmax = {span[W-1:1], 1'b0};
        else if (span[1])
            kmax = {span[W-1:2], 2'b01};
        else
            kmax = span;

        // distance to the neighbouring kept offset in scan direction
        if (!sub_en)
            stride = W'(1);
        else if (!sub_color)
            stride = W'(2);
        else if (idx[0] ^ rev)
            stride = W'(3);
        else
            stride = W'(1);

        first_idx = rev ? kmax : '0;
        at_end    = (idx == (rev ? '0 : kmax));
        next_idx  = rev ? (idx - stride) : (idx + stride);
    end

endmodule

// File: rtl/roi_win_sel.sv
// Picks one region's captured fields by index.
module roi_win_sel #(
    parameter int NWIN = 4,
    parameter int YW   = 10,
    parameter int XW   = 6,
    parameter int IW   = 2
) (
    input  logic [IW-1:0]      sel,
    input  logic [NWIN*YW-1:0] ys_flat,
    input  logic [NWIN*YW-1:0] ye_flat,
    input  logic [NWIN*XW-1:0] xs_flat,
    input  logic [NWIN*XW-1:0] kn_flat,
    output logic [YW-1:0]      ys,
    output logic [YW-1:0]      ye,
    output logic [XW-1:0]      xs,
    output logic [XW-1:0]      kn
);

    logic [YW-1:0] ys_a [NWIN];
    logic [YW-1:0] ye_a [NWIN];
    logic [XW-1:0] xs_a [NWIN];
    logic [XW-1:0] kn_a [NWIN];

    for (genvar g = 0; g < NWIN; g++) begin : g_unpack
        assign ys_a[g] = ys_flat[g*YW +: YW];
        assign ye_a[g] = ye_flat[g*YW +: YW];
        assign xs_a[g] = xs_flat[g*XW +: XW];
        assign kn_a[g] = kn_flat[g*XW +: XW];
    end

    assign ys = ys_a[sel];
    assign ye = ye_a[sel];
    assign xs = xs_a[sel];
    assign kn = kn_a[sel];

endmodule

// File: rtl/roi_addr_gen.sv
module roi_addr_gen
    import roi_pkg::*;
#(
    parameter int NWIN = 4,
    parameter int YW   = 10,
    parameter int XW   = 6,
    localparam int IW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               step_en,
    input  logic [IW-1:0]      win_count,
    input  logic [NWIN*YW-1:0] y_start_flat,
    input  logic [NWIN*YW-1:0] y_end_flat,
    input  logic [NWIN*XW-1:0] x_start_flat,
    input  logic [NWIN*XW-1:0] x_kernels_flat,
    input  logic               sub_en,
    input  logic               sub_color,
    input  logic               rev_x,
    input  logic               rev_y,
    output logic [XW-1:0]      x_addr,
    output logic [YW-1:0]      y_addr,
    output logic               addr_valid,
    output logic               line_start,
    output logic               line_end,
    output logic               frame_end
);

    roi_state_t state, state_nx;

    // configuration captured at frame start
    logic [IW-1:0]      lat_cnt;
    logic [NWIN*YW-1:0] lat_ys, lat_ye;
    logic [NWIN*XW-1:0] lat_xs, lat_kn;
    roi_mode_t          lat_mode;

    logic [IW-1:0] win;
    logic [YW-1:0] row;
    logic [XW-1:0] col;

    logic [YW-1:0] cur_ys, cur_ye;
    logic [XW-1:0] cur_xs, cur_kn;

    roi_win_sel #(.NWIN(NWIN), .YW(YW), .XW(XW), .IW(IW)) u_sel (
        .sel     (win),
        .ys_flat (lat_ys),
        .ye_flat (lat_ye),
        .xs_flat (lat_xs),
        .kn_flat (lat_kn),
        .ys      (cur_ys),
        .ye      (cur_ye),
        .xs      (cur_xs),
        .kn      (cur_kn)
    );

    logic          win_empty, win_last;
    logic [YW-1:0] row_span, row_first, row_nxt;
    logic [XW-1:0] col_span, col_first, col_nxt;
    logic          row_end, col_end;

    assign win_empty = (cur_ye < cur_ys) || (cur_kn == '0);
    assign win_last  = (win == lat_cnt);
    assign row_span  = cur_ye - cur_ys;
    assign col_span  = cur_kn - XW'(1);

    roi_axis #(.W(YW)) u_row_axis (
        .idx       (row),
        .span      (row_span),
        .sub_en    (lat_mode.sub_en),
        .sub_color (lat_mode.sub_color),
        .rev       (lat_mode.rev_y),
        .first_idx (row_first),
        .next_idx  (row_nxt),
        .at_end    (row_end)
    );

    roi_axis #(.W(XW)) u_col_axis (
        .idx       (col),
        .span      (col_span),
        .sub_en    (lat_mode.sub_en),
        .sub_color (lat_mode.sub_color),
        .rev       (lat_mode.rev_x),
        .first_idx (col_first),
        .next_idx  (col_nxt),
        .at_end    (col_end)
    );

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (frame_start) state_nx = ST_SETUP;
            ST_SETUP: begin
                if (win_empty && win_last)
                    state_nx = ST_FEND;
                else if (!win_empty)
                    state_nx = ST_EMIT;
            end
            ST_EMIT: begin
                if (step_en && col_end && row_end)
                    state_nx = win_last ? ST_FEND : ST_SETUP;
            end
            ST_FEND:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // scan counters and captured configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win      <= '0;
            row      <= '0;
            col      <= '0;
            lat_cnt  <= '0;
            lat_ys   <= '0;
            lat_ye   <= '0;
            lat_xs   <= '0;
            lat_kn   <= '0;
            lat_mode <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (frame_start) begin
                        win      <= '0;
                        lat_cnt  <= win_count;
                        lat_ys   <= y_start_flat;
                        lat_ye   <= y_end_flat;
                        lat_xs   <= x_start_flat;
                        lat_kn   <= x_kernels_flat;
                        lat_mode <= {sub_en, sub_color, rev_x, rev_y};
                    end
                end
                ST_SETUP: begin
                    if (win_empty) begin
                        if (!win_last) win <= win + IW'(1);
                    end else begin
                        row <= row_first;
                        col <= col_first;
                    end
                end
                ST_EMIT: begin
                    if (step_en) begin
                        if (!col_end) begin
                            col <= col_nxt;
                        end else if (!row_end) begin
                            row <= row_nxt;
                            col <= col_first;
                        end else if (!win_last) begin
                            win <= win + IW'(1);
                        end
                    end
                end
                ST_FEND: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        addr_valid = (state == ST_EMIT);
        x_addr     = cur_xs + col;
        y_addr     = cur_ys + row;
        line_start = addr_valid && (col == col_first);
        line_end   = addr_valid && col_end;
        frame_end  = (state == ST_FEND);
    end

    // R8: a stalled address is held
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && !step_en |=> addr_valid && $stable(x_addr) && $stable(y_addr)
                                   && $stable(line_start) && $stable(line_end));

    // R10: frame end never overlaps an address and lasts one cycle
    a_r10_fend_alone: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> !addr_valid);
    a_r10_fend_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end && !addr_valid);

    // R4: row address stays inside the current region
    a_r4_row_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> (y_addr >= cur_ys) && (y_addr <= cur_ye));

    // R7: kept offsets follow the selected pattern
    a_r7_mono_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && lat_mode.sub_en && !lat_mode.sub_color |-> !row[0] && !col[0]);
    a_r7_color_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && lat_mode.sub_en && lat_mode.sub_color |-> !row[1] && !col[1]);

    // R9: a row end is followed by a row start or a region change
    a_r9_next_row_starts: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && step_en && line_end && !row_end |=> addr_valid && line_start);

endmodule

// File: tb/sim_roi_addr_gen.sv
module sim_roi_addr_gen;

    localparam int NWIN = 4;
    localparam int YW   = 10;
    localparam int XW   = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, frame_start, step_en;
    logic [1:0] win_count;
    logic [NWIN*YW-1:0] y_start_v, y_end_v;
    logic [NWIN*XW-1:0] x_start_v, x_kern_v;
    logic sub_en, sub_color, rev_x, rev_y;
    logic [XW-1:0] x_addr;
    logic [YW-1:0] y_addr;
    logic addr_valid, line_start, line_end, frame_end;

    int ys[NWIN], ye[NWIN], xs[NWIN], kn[NWIN];

    always_comb begin
        for (int i = 0; i < NWIN; i++) begin
            y_start_v[i*YW +: YW] = YW'(ys[i]);
            y_end_v[i*YW +: YW]   = YW'(ye[i]);
            x_start_v[i*XW +: XW] = XW'(xs[i]);
            x_kern_v[i*XW +: XW]  = XW'(kn[i]);
        end
    end

    roi_addr_gen #(.NWIN(NWIN), .YW(YW), .XW(XW)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .step_en(step_en),
        .win_count(win_count), .y_start_flat(y_start_v), .y_end_flat(y_end_v),
        .x_start_flat(x_start_v), .x_kernels_flat(x_kern_v),
        .sub_en(sub_en), .sub_color(sub_color), .rev_x(rev_x), .rev_y(rev_y),
        .x_addr(x_addr), .y_addr(y_addr), .addr_valid(addr_valid),
        .line_start(line_start), .line_end(line_end), .frame_end(frame_end)
    );

    typedef struct packed {
        logic [9:0] y;
        logic [5:0] x;
        logic       ls;
        logic       le;
        logic [1:0] w;
    } exp_t;

    exp_t  q[$];
    int    total = 0, bad = 0;
    string cur_req = "R1";
    int    stall_mode = 0;
    int    lfsr = 32'h1ACE5;
    bit    mon_on = 0, frame_on = 0, fend_seen = 0, prev_fend = 0, last_acc = 0;
    logic [1:0] last_w = '0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit keep(int o);
        if (!sub_en) return 1'b1;
        if (sub_color) return (o % 4) < 2;
        return (o % 2) == 0;
    endfunction

    // behavioural reference: list every expected address of the frame
    task automatic build_expect();
        int rl[$];
        int cl[$];
        exp_t e;
        q.delete();
        for (int w = 0; w <= int'(win_count); w++) begin
            if (ye[w] < ys[w] || kn[w] == 0) continue;
            rl.delete();
            cl.delete();
            for (int r = 0; r <= ye[w] - ys[w]; r++) if (keep(r)) rl.push_back(r);
            for (int c = 0; c < kn[w]; c++) if (keep(c)) cl.push_back(c);
            if (rev_y) rl.reverse();
            if (rev_x) cl.reverse();
            for (int i = 0; i < rl.size(); i++) begin
                for (int j = 0; j < cl.size(); j++) begin
                    e.y  = 10'(ys[w] + rl[i]);
                    e.x  = 6'((xs[w] + cl[j]) % 64);
                    e.ls = (j == 0);
                    e.le = (j == cl.size() - 1);
                    e.w  = 2'(w);
                    q.push_back(e);
                end
            end
        end
    endtask

    // per-cycle comparison and consumer stimulus
    initial begin
        step_en = 1'b0;
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (addr_valid) begin
                    if (q.size() == 0)
                        check(1'b0, cur_req, "address with nothing expected", int'(y_addr), -1);
                    else
                        check({y_addr, x_addr, line_start, line_end} == {q[0].y, q[0].x, q[0].ls, q[0].le},
                              cur_req, "{y,x,ls,le}",
                              int'({y_addr, x_addr, line_start, line_end}),
                              int'({q[0].y, q[0].x, q[0].ls, q[0].le}));
                end else if (last_acc && q.size() > 0 && q[0].w == last_w) begin
                    check(1'b0, "R8", "gap inside a region", 0, 1);
                end
                if (frame_end) begin
                    check(q.size() == 0 && frame_on, "R10", "frame_end with addresses left", q.size(), 0);
                    check(!prev_fend, "R10", "frame_end longer than one cycle", 2, 1);
                    fend_seen = 1;
                    frame_on  = 0;
                end
                prev_fend = frame_end;
                lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB4BCD35C : 32'h0);
                case (stall_mode)
                    0:       step_en = 1'b1;
                    1:       step_en = lfsr[3];
                    default: step_en = (lfsr[5:4] == 2'b00);
                endcase
                last_acc = 0;
                if (addr_valid && step_en && q.size() > 0) begin
                    last_w = q[0].w;
                    void'(q.pop_front());
                    last_acc = 1;
                end
            end
        end
    end

    task automatic setwin(int i, int a, int b, int c, int d);
        ys[i] = a; ye[i] = b; xs[i] = c; kn[i] = d;
    endtask

    task automatic setmode(bit se, bit sc, bit rx, bit ry);
        sub_en = se; sub_color = sc; rev_x = rx; rev_y = ry;
    endtask

    task automatic run_frame(string req, int mode, bit disturb);
        cur_req    = req;
        stall_mode = mode;
        build_expect();
        frame_on  = 1;
        fend_seen = 0;
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        if (disturb) begin
            repeat (4) @(negedge clk);
            ys[0] = ys[0] + 1;
            kn[1] = 0;
            win_count = 2'd0;
            rev_x = ~rev_x;
            sub_en = ~sub_en;
            frame_start = 1'b1;
            @(negedge clk);
            frame_start = 1'b0;
        end
        for (int t = 0; t < 20000 && !fend_seen; t++) @(negedge clk);
        check(fend_seen, req, "frame_end reached", int'(fend_seen), 1);
        check(q.size() == 0, req, "addresses left over", q.size(), 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        frame_start = 1'b0;
        win_count = 2'd0;
        for (int i = 0; i < NWIN; i++) setwin(i, 0, 0, 0, 0);
        setmode(0, 0, 0, 0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs quiet after reset and without a frame start
        check(addr_valid == 1'b0, "R1", "addr_valid after reset", int'(addr_valid), 0);
        check(frame_end == 1'b0, "R1", "frame_end after reset", int'(frame_end), 0);
        check({line_start, line_end} == 2'b00, "R1", "markers after reset", int'({line_start, line_end}), 0);
        cur_req = "R1";
        mon_on = 1;
        repeat (8) @(negedge clk);

        // R4: single region, forward scan
        setwin(0, 5, 8, 10, 7);
        win_count = 2'd0;
        run_frame("R4", 0, 0);
        // R4: column wrap past 63
        setwin(0, 100, 101, 62, 5);
        run_frame("R4", 1, 0);

        // R3: four regions in index order
        setwin(0, 0, 2, 0, 4);
        setwin(1, 20, 22, 30, 3);
        setwin(2, 500, 503, 5, 6);
        setwin(3, 1020, 1023, 60, 4);
        win_count = 2'd3;
        run_frame("R3", 0, 0);
        // R3: count 1 leaves regions 2 and 3 unread
        win_count = 2'd1;
        run_frame("R3", 1, 0);
        win_count = 2'd2;
        run_frame("R3", 2, 0);

        // R5: empty regions at start, middle and end
        setwin(0, 9, 8, 0, 4);
        setwin(1, 3, 5, 2, 3);
        setwin(2, 7, 9, 4, 0);
        setwin(3, 40, 40, 1, 2);
        win_count = 2'd3;
        run_frame("R5", 1, 0);
        setwin(3, 50, 10, 1, 2);
        run_frame("R5", 0, 0);
        // R10: every region empty, only the frame_end pulse
        setwin(1, 6, 5, 2, 3);
        setwin(3, 40, 40, 1, 0);
        run_frame("R10", 0, 0);

        // R6: reversal per axis and both
        setwin(0, 10, 16, 3, 9);
        setwin(1, 30, 33, 40, 5);
        win_count = 2'd1;
        setmode(0, 0, 1, 0);
        run_frame("R6", 0, 0);
        setmode(0, 0, 0, 1);
        run_frame("R6", 1, 0);
        setmode(0, 0, 1, 1);
        run_frame("R6", 2, 0);

        // R7: both patterns, spans covering every remainder mod 4
        setwin(0, 0, 8, 0, 10);
        setwin(1, 50, 55, 20, 11);
        setwin(2, 100, 106, 5, 12);
        setwin(3, 200, 203, 9, 9);
        win_count = 2'd3;
        setmode(1, 0, 0, 0);
        run_frame("R7", 0, 0);
        setmode(1, 1, 0, 0);
        run_frame("R7", 1, 0);
        setmode(1, 1, 1, 1);
        run_frame("R7", 0, 0);
        setmode(1, 0, 1, 0);
        run_frame("R7", 2, 0);
        setmode(1, 1, 0, 1);
        run_frame("R7", 1, 0);

        // R9: one-kernel rows carry both markers
        setwin(0, 3, 6, 12, 1);
        setwin(1, 8, 9, 63, 2);
        win_count = 2'd1;
        setmode(0, 0, 0, 0);
        run_frame("R9", 1, 0);
        setmode(1, 1, 1, 0);
        setwin(1, 8, 13, 20, 3);
        run_frame("R9", 0, 0);

        // R8: heavy stalling across several regions
        setwin(0, 0, 5, 0, 6);
        setwin(1, 7, 11, 8, 5);
        win_count = 2'd1;
        setmode(0, 0, 1, 0);
        run_frame("R8", 2, 0);

        // R2: mid-frame configuration change and extra frame start
        setwin(0, 0, 9, 0, 12);
        setwin(1, 20, 29, 10, 12);
        win_count = 2'd1;
        setmode(0, 0, 0, 0);
        run_frame("R2", 2, 1);

        mon_on = 0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule